// File: doc/BRIEF.md
# Frame commit and buffer flip controller

This block decides when a 3D frame may be rendered. It snoops single-beat writes on a memory-mapped bus and looks for two events. A data-flush write closes one DMA transfer into scene memory. A frame-end write to a display-generator control register is the final write of a frame. A frame is committed only if at least one flush has been seen since the previous frame-end. A commit starts the renderer and flips the ping-pong scene buffer pair. A frame-end that finds no flush is refused and counted.

The block also gates culling traversal. A transfer-open pulse from the DMA side pauses traversal, and the next flush write resumes it. The renderer is reached through a start pulse, a done input and the buffer index to draw from.

A status word and a fixed validity constant are offered for a host return packet. The count of refused frame-ends is exported beside them.

Top module: `frame_commit_ctrl`

## Requirements
- R1: After a synchronous reset, render_start is 0, render_buf is 0, traverse_en is 1, reject_count is 0 and ret_status is 32'h10 (traverse bit set, all other bits clear).
- R2: A bus write (wr_valid high) to address 32'h8800_0000 with any data sets the flush-seen flag, visible in ret_status bit 2 on the next cycle. Several flushes in one frame have the same effect as one.
- R3: A frame-end event is a write of exactly 3 to address 32'hF118_000C. A write of another value to that address, or of 3 to any other address, changes no output.
- R4: A frame-end with the flush flag set while the engine is idle produces, on the next cycle, a one-cycle render_start pulse. In that same cycle render_buf toggles and becomes the buffer to render, busy (ret_status bit 0) is 1 and the flush flag is clear.
- R5: A frame-end with the flush flag clear starts no render, leaves render_buf unchanged and raises reject_count by one. The count saturates at 2^REJ_W-1.
- R6: Flush writes with no frame-end never start a render or toggle render_buf.
- R7: An accepted frame-end that arrives while busy sets pending (ret_status bit 1) and clears the flush flag. The next render_done then gives, on the following cycle, a render_start pulse, a toggle of render_buf and a clear pending bit.
- R8: render_done while busy with nothing pending returns the engine to idle on the next cycle. render_done while idle has no effect.
- R9: A dma_begin pulse drives traverse_en to 0 on the next cycle, and a flush write drives it back to 1. When both arrive in the same cycle, traverse_en goes to 0.
- R10: ret_magic always reads 32'hBEEF_BABE.
- R11: ret_status carries busy in bit 0, pending in bit 1, flush flag in bit 2, buffer select in bit 3 and traverse enable in bit 4. Bits 31 to 5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| dma_begin | input | 1 | Pulse when a DMA transfer into scene memory opens |
| render_done | input | 1 | Renderer has finished the current frame |
| render_start | output | 1 | One-cycle pulse starting a render |
| render_buf | output | 1 | Ping-pong buffer index the renderer uses |
| traverse_en | output | 1 | Culling traversal allowed |
| ret_status | output | 32 | Status word for the return packet |
| ret_magic | output | 32 | Packet validity constant |
| reject_count | output | REJ_W | Saturating count of refused frame-ends |

## Verification
A table of bus and handshake patterns is driven through the block in sequence. It covers repeated flushes with no frame-end, a flush followed by a frame-end, a second commit that lands while the renderer is busy, a frame-end with no flush, writes that hit only the address or only the value of the frame-end event, and a transfer that opens in the same cycle as a flush. Each pattern separates a correct design from one that renders on any frame-end or on a flush alone, that toggles the buffer on a refusal, or that drops a commit made while busy. Directed runs then push the refusal counter past its ceiling and repeat reset in mid-stream.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int unsigned FC_STAT_W   = 32;
    localparam logic [31:0] FC_RET_MAGIC = 32'hBEEF_BABE;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_e;

    // Decoded bus events for one cycle
    typedef struct packed {
        logic flush;
        logic frame_end;
    } bus_evt_t;

    // Controller state visible to the host, LSB first: busy, pending, flush, sel, trav
    typedef struct packed {
        logic trav_en;
        logic buf_sel;
        logic flush_seen;
        logic pending;
        logic busy;
    } ctl_status_t;

    localparam int unsigned FC_CTL_W = $bits(ctl_status_t);

    function automatic logic [FC_STAT_W-1:0] pack_status(input ctl_status_t s);
        logic [FC_STAT_W-1:0] w;
        w = '0;
        w[FC_CTL_W-1:0] = s;
        return w;
    endfunction

endpackage

// File: rtl/fc_bus_decode.sv
module fc_bus_decode
    import fc_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 32,
    parameter int unsigned        DATA_W     = 32,
    parameter logic [ADDR_W-1:0]  FLUSH_ADDR = 32'h8800_0000,
    parameter logic [ADDR_W-1:0]  FEND_ADDR  = 32'hF118_000C,
    parameter logic [DATA_W-1:0]  FEND_VALUE = 32'd3
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output bus_evt_t          evt
);

    always_comb begin
        evt.flush     = wr_valid && (wr_addr == FLUSH_ADDR);
        evt.frame_end = wr_valid && (wr_addr == FEND_ADDR) && (wr_data == FEND_VALUE);
    end

endmodule

// File: rtl/fc_traverse_gate.sv
module fc_traverse_gate (
    input  logic clk,
    input  logic rst,
    input  logic dma_begin,
    input  logic flush,
    output logic trav_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            trav_en <= 1'b1;
        end else if (dma_begin) begin
            // a newly opened transfer outranks a flush in the same cycle
            trav_en <= 1'b0;
        end else if (flush) begin
            trav_en <= 1'b1;
        end
    end

endmodule

// File: rtl/fc_commit_ctrl.sv
module fc_commit_ctrl
    import fc_pkg::*;
#(
    parameter int unsigned REJ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic             render_done,
    output logic             render_start,
    output logic             buf_sel,
    output logic             busy,
    output logic             pending,
    output logic             flush_seen,
    output logic [REJ_W-1:0] reject_count
);

    localparam logic [REJ_W-1:0] REJ_MAX = {REJ_W{1'b1}};

    eng_state_e st_q, st_n;
    logic       flush_q, flush_n;
    logic       pend_q, pend_n;
    logic       sel_q;
    logic       start_q;
    logic [REJ_W-1:0] rej_q;

    logic commit, refuse, start;

    always_comb begin
        commit = evt.frame_end &  flush_q;
        refuse = evt.frame_end & ~flush_q;

        start = ((st_q == ENG_IDLE) & commit) |
                ((st_q == ENG_BUSY) & render_done & (pend_q | commit));

        // flush flag: frame-end clears, any flush sets
        if (evt.frame_end)  flush_n = 1'b0;
        else if (evt.flush) flush_n = 1'b1;
        else                flush_n = flush_q;

        // pending commit queue of depth one
        pend_n = 1'b0;
        if (st_q == ENG_BUSY) begin
            if (render_done) pend_n = pend_q & commit;
            else             pend_n = pend_q | commit;
        end

        st_n = st_q;
        if (start)                                    st_n = ENG_BUSY;
        else if ((st_q == ENG_BUSY) && render_done)   st_n = ENG_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ENG_IDLE;
            flush_q <= 1'b0;
            pend_q  <= 1'b0;
            sel_q   <= 1'b0;
            start_q <= 1'b0;
            rej_q   <= '0;
        end else begin
            st_q    <= st_n;
            flush_q <= flush_n;
            pend_q  <= pend_n;
            start_q <= start;
            if (start) sel_q <= ~sel_q;
            if (refuse && (rej_q != REJ_MAX)) rej_q <= rej_q + 1'b1;
        end
    end

    assign render_start = start_q;
    assign buf_sel      = sel_q;
    assign busy         = (st_q == ENG_BUSY);
    assign pending      = pend_q;
    assign flush_seen   = flush_q;
    assign reject_count = rej_q;

endmodule

// File: rtl/frame_commit_ctrl.sv
module frame_commit_ctrl
    import fc_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 32,
    parameter int unsigned        DATA_W     = 32,
    parameter int unsigned        REJ_W      = 8,
    parameter logic [ADDR_W-1:0]  FLUSH_ADDR = 32'h8800_0000,
    parameter logic [ADDR_W-1:0]  FEND_ADDR  = 32'hF118_000C,
    parameter logic [DATA_W-1:0]  FEND_VALUE = 32'd3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  dma_begin,
    input  logic                  render_done,
    output logic                  render_start,
    output logic                  render_buf,
    output logic                  traverse_en,
    output logic [FC_STAT_W-1:0]  ret_status,
    output logic [31:0]           ret_magic,
    output logic [REJ_W-1:0]      reject_count
);

    bus_evt_t    evt;
    ctl_status_t st;

    fc_bus_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FLUSH_ADDR (FLUSH_ADDR),
        .FEND_ADDR  (FEND_ADDR),
        .FEND_VALUE (FEND_VALUE)
    ) i_decode (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .evt      (evt)
    );

    fc_commit_ctrl #(
        .REJ_W (REJ_W)
    ) i_commit (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .render_done  (render_done),
        .render_start (render_start),
        .buf_sel      (st.buf_sel),
        .busy         (st.busy),
        .pending      (st.pending),
        .flush_seen   (st.flush_seen),
        .reject_count (reject_count)
    );

    fc_traverse_gate i_trav (
        .clk       (clk),
        .rst       (rst),
        .dma_begin (dma_begin),
        .flush     (evt.flush),
        .trav_en   (st.trav_en)
    );

    assign render_buf  = st.buf_sel;
    assign traverse_en = st.trav_en;
    assign ret_status  = pack_status(st);
    assign ret_magic   = FC_RET_MAGIC;

endmodule

// File: rtl/frame_commit_ctrl_chk.sv
module frame_commit_ctrl_chk #(
    parameter int unsigned        ADDR_W     = 32,
    parameter int unsigned        DATA_W     = 32,
    parameter int unsigned        REJ_W      = 8,
    parameter logic [ADDR_W-1:0]  FLUSH_ADDR = 32'h8800_0000,
    parameter logic [ADDR_W-1:0]  FEND_ADDR  = 32'hF118_000C,
    parameter logic [DATA_W-1:0]  FEND_VALUE = 32'd3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              dma_begin,
    input logic              render_start,
    input logic              render_buf,
    input logic              traverse_en,
    input logic [31:0]       ret_status,
    input logic [REJ_W-1:0]  reject_count
);

    logic fl_wr, fe_wr;
    assign fl_wr = wr_valid && (wr_addr == FLUSH_ADDR);
    assign fe_wr = wr_valid && (wr_addr == FEND_ADDR) && (wr_data == FEND_VALUE);

    assert_flip_on_start_R4: assert property (@(posedge clk) disable iff (rst)
        render_start |-> (render_buf != $past(render_buf)));

    assert_flip_only_on_start_R6: assert property (@(posedge clk) disable iff (rst)
        !render_start |-> $stable(render_buf));

    assert_busy_with_start_R4: assert property (@(posedge clk) disable iff (rst)
        render_start |-> ret_status[0]);

    assert_no_render_without_flush_R5: assert property (@(posedge clk) disable iff (rst)
        (fe_wr && !ret_status[2] && !ret_status[1]) |=> !render_start);

    assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        fe_wr |=> !ret_status[2]);

    assert_reject_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
        reject_count >= $past(reject_count));

    assert_traverse_resume_R9: assert property (@(posedge clk) disable iff (rst)
        (fl_wr && !dma_begin) |=> traverse_en);

    assert_traverse_pause_R9: assert property (@(posedge clk) disable iff (rst)
        dma_begin |=> !traverse_en);

    assert_status_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
        ret_status[31:5] == '0);

endmodule

bind frame_commit_ctrl frame_commit_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REJ_W      (REJ_W),
    .FLUSH_ADDR (FLUSH_ADDR),
    .FEND_ADDR  (FEND_ADDR),
    .FEND_VALUE (FEND_VALUE)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .dma_begin    (dma_begin),
    .render_start (render_start),
    .render_buf   (render_buf),
    .traverse_en  (traverse_en),
    .ret_status   (ret_status),
    .reject_count (reject_count)
);

// File: tb/test_frame_commit_ctrl.sv
module test_frame_commit_ctrl;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned REJ_W      = 8;
    localparam logic [31:0] A_FLUSH = 32'h8800_0000;
    localparam logic [31:0] A_FEND  = 32'hF118_000C;
    localparam logic [31:0] A_OTHER = 32'hF118_0008;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic        dma;
        logic        done;
        logic        exp_start;
        logic [4:0]  exp_st;   // {trav, sel, flush, pending, busy}
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{4'd2,  1'b1, A_FLUSH, 32'h1234, 1'b0, 1'b0, 1'b0, 5'b10100}, // R2 flush sets flag
        '{4'd6,  1'b1, A_FLUSH, 32'h0,    1'b0, 1'b0, 1'b0, 5'b10100}, // R6 repeat flush, no render
        '{4'd4,  1'b1, A_FEND,  32'd3,    1'b0, 1'b0, 1'b1, 5'b11001}, // R4 commit and flip
        '{4'd4,  1'b0, 32'h0,   32'h0,    1'b0, 1'b0, 1'b0, 5'b11001}, // R4 start is one cycle
        '{4'd2,  1'b1, A_FLUSH, 32'h5,    1'b0, 1'b0, 1'b0, 5'b11101}, // R2 flush while busy
        '{4'd7,  1'b1, A_FEND,  32'd3,    1'b0, 1'b0, 1'b0, 5'b11011}, // R7 commit while busy -> pending
        '{4'd7,  1'b0, 32'h0,   32'h0,    1'b0, 1'b1, 1'b1, 5'b10001}, // R7 done serves pending
        '{4'd8,  1'b0, 32'h0,   32'h0,    1'b0, 1'b1, 1'b0, 5'b10000}, // R8 done -> idle
        '{4'd5,  1'b1, A_FEND,  32'd3,    1'b0, 1'b0, 1'b0, 5'b10000}, // R5 frame-end without flush
        '{4'd3,  1'b1, A_FEND,  32'd2,    1'b0, 1'b0, 1'b0, 5'b10000}, // R3 wrong value ignored
        '{4'd9,  1'b0, 32'h0,   32'h0,    1'b1, 1'b0, 1'b0, 5'b00000}, // R9 transfer opens
        '{4'd9,  1'b1, A_FLUSH, 32'h0,    1'b0, 1'b0, 1'b0, 5'b10100}, // R9 flush resumes
        '{4'd9,  1'b1, A_FLUSH, 32'h0,    1'b1, 1'b0, 1'b0, 5'b00100}, // R9 both -> paused
        '{4'd3,  1'b1, A_OTHER, 32'd3,    1'b0, 1'b0, 1'b0, 5'b00100}, // R3 wrong address ignored
        '{4'd4,  1'b1, A_FEND,  32'd3,    1'b0, 1'b0, 1'b1, 5'b01001}, // R4 second flip
        '{4'd8,  1'b0, 32'h0,   32'h0,    1'b0, 1'b1, 1'b0, 5'b01000}, // R8 done -> idle
        '{4'd8,  1'b0, 32'h0,   32'h0,    1'b0, 1'b1, 1'b0, 5'b01000}  // R8 done while idle ignored
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic [31:0]       wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              dma_begin = 1'b0;
    logic              render_done = 1'b0;
    logic              render_start;
    logic              render_buf;
    logic              traverse_en;
    logic [31:0]       ret_status;
    logic [31:0]       ret_magic;
    logic [REJ_W-1:0]  reject_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_commit_ctrl #(.REJ_W(REJ_W)) i_frame_commit_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .dma_begin    (dma_begin),
        .render_done  (render_done),
        .render_start (render_start),
        .render_buf   (render_buf),
        .traverse_en  (traverse_en),
        .ret_status   (ret_status),
        .ret_magic    (ret_magic),
        .reject_count (reject_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        dma_begin = 1'b0; render_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_reset_state();
        // R1 reset values
        check("R1 render_start", {31'b0, render_start}, 32'd0);
        check("R1 render_buf",   {31'b0, render_buf},   32'd0);
        check("R1 traverse_en",  {31'b0, traverse_en},  32'd1);
        check("R1 reject_count", 32'(reject_count),     32'd0);
        check("R1 ret_status",   ret_status,            32'h10);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        check_reset_state();
        check("R10 ret_magic", ret_magic, 32'hBEEF_BABE);

        for (int i = 0; i < NVEC; i++) begin
            wr_valid    = VEC[i].wr;
            wr_addr     = VEC[i].addr;
            wr_data     = VEC[i].data;
            dma_begin   = VEC[i].dma;
            render_done = VEC[i].done;
            @(negedge clk);
            idle_inputs();
            check($sformatf("R%0d vec%0d render_start", VEC[i].req, i),
                  {31'b0, render_start}, {31'b0, VEC[i].exp_start});
            check($sformatf("R%0d vec%0d ret_status (R11 layout)", VEC[i].req, i),
                  ret_status, {27'b0, VEC[i].exp_st});
            check($sformatf("R%0d vec%0d render_buf", VEC[i].req, i),
                  {31'b0, render_buf}, {31'b0, VEC[i].exp_st[3]});
        end

        // R5 one refusal seen in the table
        check("R5 reject_count after table", 32'(reject_count), 32'd1);

        // R5 saturation of the refusal counter
        for (int k = 0; k < 300; k++) begin
            wr_valid = 1'b1; wr_addr = A_FEND; wr_data = 32'd3;
            @(negedge clk);
        end
        idle_inputs();
        @(negedge clk);
        check("R5 reject_count saturates", 32'(reject_count), 32'd255);
        check("R5 no flip during refusals", {31'b0, render_buf}, 32'd1);
        check("R10 ret_magic stable", ret_magic, 32'hBEEF_BABE);

        // R6 long run of flushes alone never starts a render
        begin
            int starts = 0;
            for (int k = 0; k < 20; k++) begin
                wr_valid = 1'b1; wr_addr = A_FLUSH; wr_data = 32'(k);
                @(negedge clk);
                if (render_start) starts++;
            end
            idle_inputs();
            check("R6 starts after flushes only", 32'(starts), 32'd0);
        end

        // R1 reset in mid-stream with flag set and buffer at 1
        do_reset();
        check_reset_state();

        finish_run();
    end

endmodule